// File: doc/BRIEF.md
# Cache Hint Line Controller

This block keeps the tags and per-line state of a small two-way set-associative data cache with 64-byte lines. It carries out cache-management hints, one at a time. A hint arrives as an opcode and a byte address. The controller looks the line up in both ways and updates the valid, dirty and evict-next bits of the line it touches. When a hint needs memory, it sends a whole-block read or writeback request on a simple request/acknowledge port. The data array, ordinary loads and stores, coherence and any outer cache belong to other blocks.

Five hints are supported:
- a plain prefetch, which installs the line clean;
- a prefetch that installs the line already dirty, so later stores need no state change;
- a prefetch that marks the line as the first to be replaced in its set;
- a claim, which installs a writable, zeroed line without reading memory;
- a drop, which removes the line and writes it back first if it is dirty.

When the controller needs a way to replace, it takes an empty way first, then a way marked evict-next, then the least recently used way. A one-cycle completion pulse ends every hint. With it come flags that tell whether the line was already present and whether the data array must clear the line.

Top module: `hint_line_ctrl`

## Requirements
- R1: A command is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that edge through the cycle in which `done` is high, and rises in the cycle after. `done` is high for exactly one cycle per command.
- R2: Opcode 0 (plain prefetch) on a miss issues exactly one read request (`mem_req_write` = 0) for the block address. It installs the line clean, so a later drop of it writes nothing back.
- R3: Opcode 1 (prefetch for modify) on a miss issues one read request and installs the line dirty, so a later drop writes it back.
- R4: Opcode 2 (prefetch, evict next) on a miss issues one read and installs the line with its evict-next mark set. The next miss in that set replaces this line even when it is the most recently used way.
- R5: Opcode 3 (claim) on a miss issues no read request. It installs the line valid and dirty, and raises `done_zero` together with `done`.
- R6: Opcode 4 (drop) removes a line that hits:
  - a clean line goes with no memory traffic;
  - a dirty line goes after one write request (`mem_req_write` = 1) to its block address completes.
  - A drop that misses causes no traffic.
  - A dropped line misses on its next lookup.
- R7: A hint that hits causes no memory traffic and raises `done_hit` with `done`. Opcodes 1 and 3 set dirty on a hit. Opcode 0 clears evict-next on a hit. Every hit makes the line most recently used.
- R8: On a miss, the victim is chosen in this order: an invalid way (way 0 before way 1), then a way marked evict-next (way 0 before way 1), then the least recently used way of the set.
- R9: When the victim is valid and dirty, a write request for the victim's block address completes before the read request for the new block is issued.
- R10: A memory request keeps `mem_req_valid`, `mem_req_write` and `mem_req_addr` steady until `mem_ack`. Every request address has its six low bits at zero.
- R11: Opcodes 5 to 7 complete with `done`, cause no traffic, report `done_hit` = 0 and change no line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Hint command present |
| cmd_op | input | 3 | Hint opcode |
| cmd_addr | input | ADDR_W | Byte address inside the target block |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| done | output | 1 | One-cycle completion pulse |
| done_hit | output | 1 | With `done`: the line was present at lookup |
| done_zero | output | 1 | With `done`: data array must clear the line (claim miss) |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_write | output | 1 | 1 = block writeback, 0 = block fill read |
| mem_req_addr | output | ADDR_W | Block-aligned request address |
| mem_ack | input | 1 | Memory completes the pending request |

## Verification
Each hint is applied on both a miss and a hit. The number, direction and address of the memory requests then tell a clean install from a dirty one. They also separate an install that reads memory from one that does not.

Line state that is not visible at the ports is made visible through later traffic:
- a drop after a hint shows whether the dirty bit was set;
- a later miss in the same set shows whether the evict-next and LRU bits chose the intended victim.

Three set patterns cover the victim order: one with a purely LRU victim, one with an evict-next victim that is more recent than its partner, and one where a plain-prefetch hit clears the mark. A set with two dirty ways shows the order of writeback before fill. Unused opcodes are sent to a present line, and a following hit confirms they left it alone.

// File: rtl/hlc_pkg.sv
package hlc_pkg;

  // hint opcodes
  localparam logic [2:0] HINT_FETCH      = 3'd0;
  localparam logic [2:0] HINT_FETCH_MOD  = 3'd1;
  localparam logic [2:0] HINT_FETCH_NEXT = 3'd2;
  localparam logic [2:0] HINT_CLAIM      = 3'd3;
  localparam logic [2:0] HINT_DROP       = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WBACK,
    ST_FILL,
    ST_DONE
  } ctl_state_e;

  function automatic logic op_is_known(input logic [2:0] op);
    return op <= HINT_DROP;
  endfunction

  function automatic logic op_reads_mem(input logic [2:0] op);
    return (op == HINT_FETCH) || (op == HINT_FETCH_MOD) || (op == HINT_FETCH_NEXT);
  endfunction

  function automatic logic op_marks_dirty(input logic [2:0] op);
    return (op == HINT_FETCH_MOD) || (op == HINT_CLAIM);
  endfunction

  // evict-next value after the hint: on a hit, a plain fetch clears it,
  // an evict-next fetch sets it, anything else keeps it
  function automatic logic op_next_mark(input logic [2:0] op, input logic hit,
                                        input logic cur);
    if (!hit) return op == HINT_FETCH_NEXT;
    if (op == HINT_FETCH) return 1'b0;
    if (op == HINT_FETCH_NEXT) return 1'b1;
    return cur;
  endfunction

  // order: empty way, evict-next way, LRU way (lru holds the LRU index)
  function automatic logic choose_victim(input logic [1:0] vld, input logic [1:0] mark,
                                         input logic lru);
    if (!vld[0]) return 1'b0;
    if (!vld[1]) return 1'b1;
    if (mark[0]) return 1'b0;
    if (mark[1]) return 1'b1;
    return lru;
  endfunction

endpackage

// File: rtl/hlc_way_store.sv
module hlc_way_store #(
  parameter int SETS  = 16,
  parameter int TAG_W = 22
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SETS)-1:0]  idx,
  input  logic                     wr_en,
  input  logic                     wr_valid,
  input  logic                     wr_dirty,
  input  logic                     wr_mark,
  input  logic [TAG_W-1:0]         wr_tag,
  output logic                     rd_valid,
  output logic                     rd_dirty,
  output logic                     rd_mark,
  output logic [TAG_W-1:0]         rd_tag
);
  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;
  logic [SETS-1:0]  mark_q;
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      mark_q  <= '0;
    end else if (wr_en) begin
      valid_q[idx] <= wr_valid;
      dirty_q[idx] <= wr_dirty;
      mark_q[idx]  <= wr_mark;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[idx] <= wr_tag;
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_mark  = mark_q[idx];
  assign rd_tag   = tag_q[idx];
endmodule

// File: rtl/hlc_victim_pick.sv
module hlc_victim_pick
  import hlc_pkg::*;
(
  input  logic [1:0] way_valid,
  input  logic [1:0] way_mark,
  input  logic       lru_way,
  output logic       victim
);
  assign victim = choose_victim(way_valid, way_mark, lru_way);
endmodule

// File: rtl/hint_line_ctrl.sv
module hint_line_ctrl
  import hlc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SETS        = 16,
  parameter int BLOCK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ready,
  output logic              done,
  output logic              done_hit,
  output logic              done_zero,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_ack
);
  localparam int WAYS  = 2;
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(BLOCK_BYTES - 1);

  ctl_state_e        state_q, state_d;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] line_q;
  logic              hit_q;
  logic [SETS-1:0]   lru_q;

  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;

  // named internal events
  logic accept;
  logic commit;
  logic wr_go;
  logic lk_hit;
  logic hit_way;
  logic vic_way;
  logic tgt_way;
  logic need_wb;
  logic need_fill;

  logic [WAYS-1:0]  w_valid, w_dirty, w_mark, w_hit, w_wr;
  logic [TAG_W-1:0] w_tag [WAYS];

  logic             sel_valid, sel_dirty, sel_mark;
  logic [TAG_W-1:0] sel_tag;
  logic             new_valid, new_dirty, new_mark;

  assign accept = cmd_valid && cmd_ready;
  assign idx_q  = line_q[OFF_W +: IDX_W];
  assign tag_q  = line_q[ADDR_W-1 -: TAG_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      line_q  <= '0;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= cmd_op;
        line_q <= cmd_addr & BLK_MASK;
      end
      if (state_q == ST_LOOK) hit_q <= lk_hit && op_is_known(op_q);
    end
  end

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      hlc_way_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (idx_q),
        .wr_en    (w_wr[w]),
        .wr_valid (new_valid),
        .wr_dirty (new_dirty),
        .wr_mark  (new_mark),
        .wr_tag   (tag_q),
        .rd_valid (w_valid[w]),
        .rd_dirty (w_dirty[w]),
        .rd_mark  (w_mark[w]),
        .rd_tag   (w_tag[w])
      );
      assign w_hit[w] = w_valid[w] && (w_tag[w] == tag_q);
      assign w_wr[w]  = wr_go && (tgt_way == 1'(w));
    end
  endgenerate

  hlc_victim_pick u_pick (
    .way_valid (w_valid),
    .way_mark  (w_mark),
    .lru_way   (lru_q[idx_q]),
    .victim    (vic_way)
  );

  assign lk_hit    = |w_hit;
  assign hit_way   = w_hit[1];
  assign tgt_way   = lk_hit ? hit_way : vic_way;
  assign sel_valid = w_valid[tgt_way];
  assign sel_dirty = w_dirty[tgt_way];
  assign sel_mark  = w_mark[tgt_way];
  assign sel_tag   = w_tag[tgt_way];

  assign need_wb   = op_is_known(op_q) &&
                     ((op_q == HINT_DROP) ? (lk_hit && sel_dirty)
                                          : (!lk_hit && sel_valid && sel_dirty));
  assign need_fill = !lk_hit && op_reads_mem(op_q);

  always_comb begin
    if (op_q == HINT_DROP) begin
      new_valid = 1'b0;
      new_dirty = 1'b0;
      new_mark  = 1'b0;
    end else begin
      new_valid = 1'b1;
      new_dirty = (lk_hit && sel_dirty) || op_marks_dirty(op_q);
      new_mark  = op_next_mark(op_q, lk_hit, sel_mark);
    end
  end

  always_comb begin
    state_d = state_q;
    commit  = 1'b0;
    case (state_q)
      ST_IDLE:  if (cmd_valid) state_d = ST_LOOK;
      ST_LOOK: begin
        if (need_wb)        state_d = ST_WBACK;
        else if (need_fill) state_d = ST_FILL;
        else begin
          state_d = ST_DONE;
          commit  = 1'b1;
        end
      end
      ST_WBACK: if (mem_ack) begin
        if (need_fill) state_d = ST_FILL;
        else begin
          state_d = ST_DONE;
          commit  = 1'b1;
        end
      end
      ST_FILL: if (mem_ack) begin
        state_d = ST_DONE;
        commit  = 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign wr_go = commit && op_is_known(op_q) && (lk_hit || (op_q != HINT_DROP));

  always_ff @(posedge clk) begin
    if (!rst_n) lru_q <= '0;
    else if (wr_go && (op_q != HINT_DROP)) lru_q[idx_q] <= ~tgt_way;
  end

  assign cmd_ready     = (state_q == ST_IDLE);
  assign done          = (state_q == ST_DONE);
  assign done_hit      = done && hit_q;
  assign done_zero     = done && (op_q == HINT_CLAIM) && !hit_q;
  assign mem_req_valid = (state_q == ST_WBACK) || (state_q == ST_FILL);
  assign mem_req_write = (state_q == ST_WBACK);
  assign mem_req_addr  = (state_q == ST_WBACK) ? {sel_tag, idx_q, OFF_W'(0)} : line_q;
endmodule

// File: rtl/hlc_checker.sv
module hlc_checker
  import hlc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              done,
  input logic              mem_req_valid,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_ack,
  input logic [2:0]        op_q
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  assert_busy_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_ready);

  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_ack |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  assert_req_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

  assert_claim_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_write |-> op_q != HINT_CLAIM);

  assert_drop_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_write |-> op_q != HINT_DROP);

  assert_unused_op_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> op_is_known(op_q));
endmodule

bind hint_line_ctrl hlc_checker #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_chk (.*);

// File: tb/hint_line_ctrl_tb.sv
module hint_line_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd_op = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic              cmd_ready, done, done_hit, done_zero;
  logic              mem_req_valid, mem_req_write;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_ack = 1'b0;

  hint_line_ctrl u_dut (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_addr, .cmd_ready, .done,
    .done_hit, .done_zero, .mem_req_valid, .mem_req_write, .mem_req_addr, .mem_ack
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural memory: acknowledges each request after a short wait and logs it
  logic              tr_wr     [64];
  logic [ADDR_W-1:0] tr_addr   [64];
  logic              tr_stable [64];
  int                tr_total = 0;
  int                wcnt = 0;
  logic [ADDR_W-1:0] first_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req_valid && !mem_ack) begin
        if (wcnt == 0) first_addr <= mem_req_addr;
        if (wcnt == 2) begin
          mem_ack                <= 1'b1;
          wcnt                   <= 0;
          tr_wr[tr_total % 64]     <= mem_req_write;
          tr_addr[tr_total % 64]   <= mem_req_addr;
          tr_stable[tr_total % 64] <= (mem_req_addr == first_addr);
          tr_total               <= tr_total + 1;
        end else begin
          wcnt <= wcnt + 1;
        end
      end
    end
  end

  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int set, input int off);
    return ADDR_W'((tag << 10) | (set << 6) | off);
  endfunction

  task automatic hint(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                      output int start, output int cnt, output logic hit, output logic zero);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_addr  = a;
    start     = tr_total;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R1", "ready after accept", cmd_ready, 0);
    while (!done) @(negedge clk);
    hit  = done_hit;
    zero = done_zero;
    cnt  = tr_total - start;
    @(negedge clk);
    chk(cmd_ready == 1'b1 && done == 1'b0, "R1", "ready/done after completion",
        {cmd_ready, done}, 2'b10);
  endtask

  // check one logged transfer
  task automatic chk_tr(input int idx, input logic wr, input logic [ADDR_W-1:0] a,
                        input string req);
    chk(tr_wr[idx % 64] == wr, req, "request direction", tr_wr[idx % 64], wr);
    chk(tr_addr[idx % 64] == a, req, "request address", tr_addr[idx % 64], a);
    chk(tr_stable[idx % 64] == 1'b1, "R10", "address held until ack", tr_stable[idx % 64], 1);
  endtask

  task automatic t_reset();
    chk(cmd_ready == 1'b1, "R1", "reset ready", cmd_ready, 1);
    chk(mem_req_valid == 1'b0, "R10", "reset request", mem_req_valid, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
  endtask

  task automatic t_plain_fetch();
    int s, c; logic h, z;
    hint(3'd0, mk(5, 1, 'h24), s, c, h, z);
    chk(c == 1 && h == 0, "R2", "miss traffic/hit", {c, h}, {32'd1, 1'b0});
    chk_tr(s, 1'b0, mk(5, 1, 0), "R2");
    hint(3'd0, mk(5, 1, 3), s, c, h, z);
    chk(c == 0 && h == 1, "R7", "hit no traffic", {c, h}, {32'd0, 1'b1});
    hint(3'd4, mk(5, 1, 0), s, c, h, z);
    chk(c == 0 && h == 1, "R2", "drop of clean line", {c, h}, {32'd0, 1'b1});
    hint(3'd0, mk(5, 1, 0), s, c, h, z);
    chk(c == 1 && h == 0, "R6", "dropped line misses", {c, h}, {32'd1, 1'b0});
  endtask

  task automatic t_fetch_modify();
    int s, c; logic h, z;
    hint(3'd1, mk(7, 2, 8), s, c, h, z);
    chk(c == 1 && h == 0, "R3", "miss fill", {c, h}, {32'd1, 1'b0});
    chk_tr(s, 1'b0, mk(7, 2, 0), "R3");
    hint(3'd4, mk(7, 2, 0), s, c, h, z);
    chk(c == 1, "R3", "dirty drop writeback count", c, 1);
    chk_tr(s, 1'b1, mk(7, 2, 0), "R6");
    hint(3'd4, mk(7, 2, 0), s, c, h, z);
    chk(c == 0 && h == 0, "R6", "drop miss quiet", {c, h}, {32'd0, 1'b0});
  endtask

  task automatic t_claim();
    int s, c; logic h, z;
    hint(3'd3, mk(9, 3, 0), s, c, h, z);
    chk(c == 0 && h == 0 && z == 1, "R5", "claim miss", {c, h, z}, {32'd0, 2'b01});
    hint(3'd4, mk(9, 3, 0), s, c, h, z);
    chk(c == 1, "R5", "claimed line dirty", c, 1);
    chk_tr(s, 1'b1, mk(9, 3, 0), "R5");
  endtask

  task automatic t_lru();
    int s, c; logic h, z;
    hint(3'd0, mk(1, 4, 0), s, c, h, z);
    hint(3'd0, mk(2, 4, 0), s, c, h, z);
    chk(c == 1 && h == 0, "R8", "second way filled", {c, h}, {32'd1, 1'b0});
    hint(3'd0, mk(1, 4, 0), s, c, h, z);
    chk(h == 1, "R8", "first line still present", h, 1);
    hint(3'd0, mk(3, 4, 0), s, c, h, z);
    chk(c == 1, "R8", "LRU replacement fill", c, 1);
    chk_tr(s, 1'b0, mk(3, 4, 0), "R8");
    hint(3'd0, mk(1, 4, 0), s, c, h, z);
    chk(h == 1 && c == 0, "R8", "MRU line kept", {c, h}, {32'd0, 1'b1});
    hint(3'd0, mk(2, 4, 0), s, c, h, z);
    chk(h == 0 && c == 1, "R8", "LRU line replaced", {c, h}, {32'd1, 1'b0});
  endtask

  task automatic t_evict_next();
    int s, c; logic h, z;
    hint(3'd0, mk(1, 5, 0), s, c, h, z);
    hint(3'd2, mk(2, 5, 0), s, c, h, z);
    chk(c == 1 && h == 0, "R4", "marked fill", {c, h}, {32'd1, 1'b0});
    hint(3'd0, mk(3, 5, 0), s, c, h, z);
    chk(c == 1, "R4", "replacement fill", c, 1);
    hint(3'd0, mk(1, 5, 0), s, c, h, z);
    chk(h == 1 && c == 0, "R4", "unmarked LRU line kept", {c, h}, {32'd0, 1'b1});
    hint(3'd0, mk(2, 5, 0), s, c, h, z);
    chk(h == 0, "R8", "marked line was victim", h, 0);
  endtask

  task automatic t_mark_clear();
    int s, c; logic h, z;
    hint(3'd0, mk(1, 6, 0), s, c, h, z);
    hint(3'd2, mk(2, 6, 0), s, c, h, z);
    hint(3'd0, mk(2, 6, 0), s, c, h, z);
    chk(h == 1 && c == 0, "R7", "hit on marked line", {c, h}, {32'd0, 1'b1});
    hint(3'd0, mk(3, 6, 0), s, c, h, z);
    hint(3'd0, mk(2, 6, 0), s, c, h, z);
    chk(h == 1, "R7", "cleared mark keeps line", h, 1);
  endtask

  task automatic t_dirty_victim();
    int s, c; logic h, z;
    hint(3'd1, mk(1, 7, 0), s, c, h, z);
    hint(3'd1, mk(2, 7, 0), s, c, h, z);
    hint(3'd0, mk(3, 7, 4), s, c, h, z);
    chk(c == 2, "R9", "writeback plus fill", c, 2);
    chk_tr(s, 1'b1, mk(1, 7, 0), "R9");
    chk_tr(s + 1, 1'b0, mk(3, 7, 0), "R9");
  endtask

  task automatic t_modify_hit();
    int s, c; logic h, z;
    hint(3'd0, mk(1, 8, 0), s, c, h, z);
    hint(3'd1, mk(1, 8, 0), s, c, h, z);
    chk(h == 1 && c == 0, "R7", "modify hit quiet", {c, h}, {32'd0, 1'b1});
    hint(3'd4, mk(1, 8, 0), s, c, h, z);
    chk(c == 1, "R7", "modify hit set dirty", c, 1);
    chk_tr(s, 1'b1, mk(1, 8, 0), "R7");
  endtask

  task automatic t_unused_ops();
    int s, c; logic h, z;
    hint(3'd5, mk(5, 1, 0), s, c, h, z);
    chk(c == 0 && h == 0 && z == 0, "R11", "opcode 5", {c, h, z}, {32'd0, 2'b00});
    hint(3'd7, mk(6, 1, 0), s, c, h, z);
    chk(c == 0 && h == 0, "R11", "opcode 7", {c, h}, {32'd0, 1'b0});
    hint(3'd0, mk(5, 1, 0), s, c, h, z);
    chk(c == 0 && h == 1, "R11", "line untouched", {c, h}, {32'd0, 1'b1});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_fetch();
    t_fetch_modify();
    t_claim();
    t_lru();
    t_evict_next();
    t_mark_clear();
    t_dirty_victim();
    t_modify_hit();
    t_unused_ops();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule